// File: doc/BRIEF.md
# Indexed Configuration Address/Data Port

This block sits on the host side of an I/O-mapped configuration access scheme. Software first loads a 32-bit index register, the configuration address, through I/O ports 0xCF8 to 0xCFB. It then reads or writes a four-byte data window at 0xCFC to 0xCFF. Each data-window access becomes a single configuration request. The request carries the bus number, the device/function number, a 10-bit dword index into the function's 4 KiB space, byte enables, a write flag and write data. The block then waits for a responder to acknowledge the request.

A CPU-side I/O access is one `io_req` pulse. It carries a 16-bit port address, a size code, a write flag and write data. The access completes with a one-cycle `io_done` pulse, and read data is valid in that cycle. The data window responds only when two things are true: bit 31 of the index register is set, and this scheme has been selected by writing the byte 0x01 to port 0xCFB. If no responder answers within `TIMEOUT` cycles, the access finishes on its own and returns all ones.

Top module: `cfg_index_port`

## Requirements
- R1: A dword write to port 0xCF8 stores all 32 bits, and a dword read of 0xCF8 returns exactly that value. Bits 1:0 are included, so writing 0x80000000 reads back 0x80000000.
- R2: Byte writes to 0xCF8, 0xCF9 or 0xCFA, and word writes to 0xCF8 or 0xCFA, change only the addressed bytes of the index register. A byte or word read of these ports returns the addressed bytes in the low lanes, with the upper bits zero.
- R3: Any byte write to 0xCFB is a mode select and leaves the index register unchanged. The value 0x01 selects the scheme, and any other value deselects it.
- R4: A window request carries the following fields from the index register: `cfg_bus` = bits 23:16, `cfg_devfn` = bits 15:8, and `cfg_dword` = {bits 27:24, bits 7:2}.
- R5: Size codes are 0 = byte, 1 = word, 2 or 3 = dword. The lane offset is: port bits 1:0 for a byte; {port bit 1, 0} for a word; 0 for a dword. `cfg_be` is 0001, 0011 or 1111 shifted left by that offset, and `cfg_wdata` is `io_wdata` shifted left by 8 × offset bits.
- R6: Window read data is the responder's dword shifted right by 8 × offset bits, then zero-extended above the access size.
- R7: If the enable bit (bit 31) is clear or the scheme is deselected, a window access raises no request. It completes one cycle after acceptance, a read returns 0xFFFFFFFF, and a write is dropped.
- R8: `cfg_req` rises in the cycle after a window access is accepted. It stays high with stable fields until the cycle in which `cfg_ack` is sampled high. `io_done` pulses in the next cycle, and `cfg_req` is low in that cycle.
- R9: If no acknowledge arrives, `cfg_req` stays high for exactly `TIMEOUT` cycles. The access then completes with read data 0xFFFFFFFF.
- R10: An access to any port outside 0xCF8 to 0xCFF produces neither `io_done` nor a request.
- R11: After reset the index register is zero, the scheme is deselected, and `cfg_req` and `io_done` are low.
- R12: An index register access (read, write or mode select) completes with `io_done` exactly one cycle after acceptance. `io_busy` is high while a window request is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | I/O access strobe, accepted when `io_busy` is low |
| io_addr | input | 16 | I/O port address |
| io_size | input | 2 | Size code: 0 byte, 1 word, 2/3 dword |
| io_we | input | 1 | Access is a write |
| io_wdata | input | 32 | Write data, right-aligned |
| io_busy | output | 1 | A window request is outstanding |
| io_done | output | 1 | Access complete pulse |
| io_rdata | output | 32 | Read data, right-aligned, valid with `io_done` |
| cfg_req | output | 1 | Configuration request valid |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Bus number |
| cfg_devfn | output | 8 | Device/function number |
| cfg_dword | output | 10 | Dword index within the function |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-placed write data |
| cfg_ack | input | 1 | Responder acknowledge |
| cfg_rdata | input | 32 | Responder read dword, valid with `cfg_ack` |

## Verification
Index register accesses and closed-window accesses are due one cycle after the accepting edge. The driver therefore checks `io_done` at the very next falling edge, and the scoreboard compares the read data there. A window request must appear one cycle after acceptance. The bench's responder checks its fields on the request's first cycle, acknowledges after a chosen delay, and checks at the following falling edge that `cfg_req` has dropped and `io_done` is high. For timeouts, the responder counts the cycles in which `cfg_req` is high, and the bench compares that count with `TIMEOUT`.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    localparam int unsigned BYTES  = 4;
    localparam int unsigned DW     = 8 * BYTES;
    localparam logic [15:0] IDX_PORT = 16'h0CF8;
    localparam logic [15:0] WIN_PORT = 16'h0CFC;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_DWALT = 2'd3
    } io_size_e;

    typedef struct packed {
        logic             we;
        logic [7:0]       bus;
        logic [7:0]       devfn;
        logic [9:0]       dword;
        logic [BYTES-1:0] be;
        logic [1:0]       lane;
        logic [DW-1:0]    wdata;
        logic [DW-1:0]    rmask;
    } cfg_txn_t;

    function automatic logic [1:0] lane_of(io_size_e sz, logic [1:0] lo);
        case (sz)
            SZ_BYTE: return lo;
            SZ_WORD: return {lo[1], 1'b0};
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [BYTES-1:0] be_of(io_size_e sz, logic [1:0] lo);
        case (sz)
            SZ_BYTE: return 4'b0001 << lane_of(sz, lo);
            SZ_WORD: return 4'b0011 << lane_of(sz, lo);
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [DW-1:0] mask_of(io_size_e sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_WORD: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg_index_reg.sv
module cfg_index_reg
    import cfg_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [BYTES-1:0] wr_be,
    input  logic [DW-1:0]    wr_data,
    input  logic             sel_wr,
    input  logic             sel_val,
    output logic [DW-1:0]    idx_q,
    output logic             sel_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            sel_q <= 1'b0;
        end else begin
            if (wr_en) begin
                for (int i = 0; i < BYTES; i++) begin
                    if (wr_be[i]) idx_q[8*i +: 8] <= wr_data[8*i +: 8];
                end
            end
            if (sel_wr) sel_q <= sel_val;
        end
    end

    // R3: a mode select alone never alters the index register
    a_r3_select_keeps_index: assert property (@(posedge clk) disable iff (rst)
        (sel_wr && !wr_en) |=> $stable(idx_q));

    // R2: bytes without enable keep their value
    a_r2_unaddressed_bytes: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_be[0]) |=> $stable(idx_q[7:0]));

endmodule

// File: rtl/cfg_win_fsm.sv
module cfg_win_fsm
    import cfg_port_pkg::*;
#(
    parameter int unsigned TIMEOUT = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  cfg_txn_t      txn_in,
    input  logic          cfg_ack,
    input  logic [DW-1:0] cfg_rdata,
    output logic          cfg_req,
    output cfg_txn_t      txn_q,
    output logic          done,
    output logic [DW-1:0] rdata
);

    localparam int unsigned CW = $clog2(TIMEOUT) + 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    typedef enum logic {W_IDLE, W_WAIT} wstate_e;

    wstate_e       state;
    logic [CW-1:0] cnt;
    logic          expire;

    assign expire  = (cnt == LAST);
    assign cfg_req = (state == W_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= W_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
            rdata <= '0;
            txn_q <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                W_IDLE: begin
                    if (start) begin
                        txn_q <= txn_in;
                        cnt   <= '0;
                        state <= W_WAIT;
                    end
                end
                W_WAIT: begin
                    if (cfg_ack) begin
                        done  <= 1'b1;
                        rdata <= (cfg_rdata >> {txn_q.lane, 3'b000}) & txn_q.rmask;
                        state <= W_IDLE;
                    end else if (expire) begin
                        done  <= 1'b1;
                        rdata <= '1;
                        state <= W_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    // R8: request held until acknowledged or expired
    a_r8_req_held: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && !cfg_ack && !expire) |=> (cfg_req && $stable(txn_q)));

    // R8: completion follows acknowledge by one cycle
    a_r8_done_after_ack: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && cfg_ack) |=> (done && !cfg_req));

    // R9: the wait counter never passes the limit
    a_r9_timeout_bounded: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> (cnt <= LAST));

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfg_port_pkg::*;
#(
    parameter int unsigned TIMEOUT = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        io_req,
    input  logic [15:0] io_addr,
    input  logic [1:0]  io_size,
    input  logic        io_we,
    input  logic [31:0] io_wdata,
    output logic        io_busy,
    output logic        io_done,
    output logic [31:0] io_rdata,
    output logic        cfg_req,
    output logic        cfg_we,
    output logic [7:0]  cfg_bus,
    output logic [7:0]  cfg_devfn,
    output logic [9:0]  cfg_dword,
    output logic [3:0]  cfg_be,
    output logic [31:0] cfg_wdata,
    input  logic        cfg_ack,
    input  logic [31:0] cfg_rdata
);

    io_size_e      sz;
    logic [1:0]    lane;
    logic          accept, hit_idx, hit_win, is_sel, win_open;
    logic [DW-1:0] idx_q;
    logic          sel_q;
    cfg_txn_t      txn_new, txn_q;
    logic          win_done;
    logic [DW-1:0] win_rdata;
    logic          loc_done;
    logic [DW-1:0] loc_rdata;

    assign sz       = io_size_e'(io_size);
    assign lane     = lane_of(sz, io_addr[1:0]);
    assign accept   = io_req && !io_busy;
    assign hit_idx  = accept && (io_addr[15:2] == IDX_PORT[15:2]);
    assign hit_win  = accept && (io_addr[15:2] == WIN_PORT[15:2]);
    assign is_sel   = hit_idx && io_we && (sz == SZ_BYTE) && (io_addr[1:0] == 2'd3);
    assign win_open = idx_q[31] && sel_q;

    cfg_index_reg u_idx (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (hit_idx && io_we && !is_sel),
        .wr_be   (be_of(sz, io_addr[1:0])),
        .wr_data (io_wdata << {lane, 3'b000}),
        .sel_wr  (is_sel),
        .sel_val (io_wdata[7:0] == 8'h01),
        .idx_q   (idx_q),
        .sel_q   (sel_q)
    );

    always_comb begin
        txn_new.we    = io_we;
        txn_new.bus   = idx_q[23:16];
        txn_new.devfn = idx_q[15:8];
        txn_new.dword = {idx_q[27:24], idx_q[7:2]};
        txn_new.be    = be_of(sz, io_addr[1:0]);
        txn_new.lane  = lane;
        txn_new.wdata = io_wdata << {lane, 3'b000};
        txn_new.rmask = mask_of(sz);
    end

    cfg_win_fsm #(.TIMEOUT(TIMEOUT)) u_win (
        .clk       (clk),
        .rst       (rst),
        .start     (hit_win && win_open),
        .txn_in    (txn_new),
        .cfg_ack   (cfg_ack),
        .cfg_rdata (cfg_rdata),
        .cfg_req   (cfg_req),
        .txn_q     (txn_q),
        .done      (win_done),
        .rdata     (win_rdata)
    );

    // Local completions: index register accesses and closed-window accesses
    always_ff @(posedge clk) begin
        if (rst) begin
            loc_done  <= 1'b0;
            loc_rdata <= '0;
        end else begin
            loc_done  <= hit_idx || (hit_win && !win_open);
            loc_rdata <= hit_idx ? ((idx_q >> {lane, 3'b000}) & mask_of(sz)) : '1;
        end
    end

    assign io_busy   = cfg_req;
    assign io_done   = loc_done | win_done;
    assign io_rdata  = win_done ? win_rdata : loc_rdata;
    assign cfg_we    = txn_q.we;
    assign cfg_bus   = txn_q.bus;
    assign cfg_devfn = txn_q.devfn;
    assign cfg_dword = txn_q.dword;
    assign cfg_be    = txn_q.be;
    assign cfg_wdata = txn_q.wdata;

    // R7: a closed window never launches a request
    a_r7_closed_no_req: assert property (@(posedge clk) disable iff (rst)
        (hit_win && !win_open) |=> !cfg_req);

    // R8: an open window access raises the request next cycle
    a_r8_req_next: assert property (@(posedge clk) disable iff (rst)
        (hit_win && win_open) |=> cfg_req);

    // R5: any request carries at least one enabled byte
    a_r5_be_nonzero: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> (cfg_be != 4'b0000));

    // R12: a local completion is due one cycle after acceptance
    a_r12_local_done: assert property (@(posedge clk) disable iff (rst)
        hit_idx |=> io_done);

    // R10: completions only follow a decoded access
    a_r10_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
        (!hit_idx && !hit_win && !cfg_req) |=> !io_done);

endmodule

// File: tb/cfg_index_port_tb.sv
module cfg_index_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TIMEOUT    = 16;

    typedef struct packed {
        logic        we;
        logic [7:0]  bus;
        logic [7:0]  devfn;
        logic [9:0]  dword;
        logic [3:0]  be;
        logic [31:0] wdata;
    } exp_req_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_req = 1'b0;
    logic [15:0] io_addr = '0;
    logic [1:0]  io_size = '0;
    logic        io_we = 1'b0;
    logic [31:0] io_wdata = '0;
    logic        io_busy, io_done;
    logic [31:0] io_rdata;
    logic        cfg_req, cfg_we;
    logic [7:0]  cfg_bus, cfg_devfn;
    logic [9:0]  cfg_dword;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int errors = 0;
    int checks = 0;
    int done_seen = 0;
    int req_rises = 0;
    int req_len = 0;
    int last_req_len = 0;
    int resp_delay = 1;
    bit no_resp = 1'b0;
    bit prev_req = 1'b0;
    bit ack_was = 1'b0;
    bit finished = 1'b0;
    logic [31:0] resp_word = 32'hDEAD_BEEF;

    string       tag_q[$];
    logic [31:0] data_q[$];
    bit          chk_q[$];
    exp_req_t    req_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_index_port #(.TIMEOUT(TIMEOUT)) dut_i (
        .clk(clk), .rst(rst),
        .io_req(io_req), .io_addr(io_addr), .io_size(io_size), .io_we(io_we),
        .io_wdata(io_wdata), .io_busy(io_busy), .io_done(io_done), .io_rdata(io_rdata),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn),
        .cfg_dword(cfg_dword), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every completion
    always @(negedge clk) begin
        if (!rst && io_done) begin
            done_seen++;
            if (tag_q.size() == 0) begin
                check("R10 unexpected completion", 32'd1, 32'd0);
            end else begin
                automatic string       t = tag_q.pop_front();
                automatic logic [31:0] d = data_q.pop_front();
                automatic bit          c = chk_q.pop_front();
                if (c) check(t, io_rdata, d);
            end
        end
    end

    // Responder: checks request fields and acknowledges after a delay
    always @(negedge clk) begin
        if (ack_was) begin
            check("R8 req low after ack", {31'd0, cfg_req}, 32'd0);
            check("R8 done after ack", {31'd0, io_done}, 32'd1);
        end
        ack_was = 1'b0;
        if (!rst && cfg_req) begin
            if (!prev_req) begin
                req_rises++;
                req_len = 0;
                if (req_q.size() == 0) begin
                    check("R7 unexpected request", 32'd1, 32'd0);
                end else begin
                    automatic exp_req_t e = req_q.pop_front();
                    check("R4 bus", {24'd0, cfg_bus}, {24'd0, e.bus});
                    check("R4 devfn", {24'd0, cfg_devfn}, {24'd0, e.devfn});
                    check("R4 dword", {22'd0, cfg_dword}, {22'd0, e.dword});
                    check("R5 be", {28'd0, cfg_be}, {28'd0, e.be});
                    check("R5 we", {31'd0, cfg_we}, {31'd0, e.we});
                    if (e.we) check("R5 wdata", cfg_wdata, e.wdata);
                end
            end
            req_len++;
            if (!no_resp && req_len == resp_delay + 1) begin
                cfg_ack   = 1'b1;
                cfg_rdata = resp_word;
                ack_was   = 1'b1;
            end else begin
                cfg_ack = 1'b0;
            end
        end else begin
            cfg_ack = 1'b0;
            if (prev_req) last_req_len = req_len;
        end
        prev_req = cfg_req;
    end

    task automatic access(input logic [15:0] a, input logic [1:0] sz, input bit we,
                          input logic [31:0] wd, input logic [31:0] exp, input bit chk,
                          input string tag, input bit local_done);
        automatic int n0 = done_seen;
        tag_q.push_back(tag);
        data_q.push_back(exp);
        chk_q.push_back(chk);
        @(negedge clk);
        io_req = 1'b1; io_addr = a; io_size = sz; io_we = we; io_wdata = wd;
        @(negedge clk);
        io_req = 1'b0;
        if (local_done) check({"R12 one-cycle completion ", tag}, {31'd0, io_done}, 32'd1);
        for (int i = 0; i < 64; i++) begin
            if (done_seen != n0) break;
            @(posedge clk);
        end
        if (done_seen == n0) check({"completion missing ", tag}, 32'd0, 32'd1);
        @(negedge clk);
    endtask

    task automatic expect_req(input bit we, input logic [3:0] be, input logic [31:0] wd);
        exp_req_t e;
        e.we = we; e.bus = 8'h12; e.devfn = 8'h34; e.dword = 10'h16A; e.be = be; e.wdata = wd;
        req_q.push_back(e);
    endtask

    task automatic stray(input logic [15:0] a);
        automatic int d0 = done_seen;
        automatic int r0 = req_rises;
        @(negedge clk);
        io_req = 1'b1; io_addr = a; io_size = 2'd2; io_we = 1'b0;
        @(negedge clk);
        io_req = 1'b0;
        repeat (6) @(negedge clk);
        check("R10 no completion outside range", done_seen - d0, 32'd0);
        check("R10 no request outside range", req_rises - r0, 32'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finish");
        finish_run();
    end

    initial begin
        automatic int r0;
        repeat (3) @(negedge clk);
        check("R11 io_done low in reset", {31'd0, io_done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R11 cfg_req low after reset", {31'd0, cfg_req}, 32'd0);
        access(16'h0CF8, 2'd2, 0, 0, 32'h0, 1, "R11 index zero after reset", 1);

        access(16'h0CF8, 2'd2, 1, 32'h8000_0000, 0, 0, "R1 write", 1);
        access(16'h0CF8, 2'd2, 0, 0, 32'h8000_0000, 1, "R1 readback 0x80000000", 1);

        // R7/R11: scheme deselected after reset, so the window is closed
        r0 = req_rises;
        access(16'h0CFC, 2'd2, 0, 0, 32'hFFFF_FFFF, 1, "R7 deselected read ones", 1);
        check("R7 no request when deselected", req_rises - r0, 32'd0);

        access(16'h0CFB, 2'd0, 1, 32'h01, 0, 0, "R3 select", 1);
        access(16'h0CF8, 2'd2, 0, 0, 32'h8000_0000, 1, "R3 index unchanged by select", 1);

        access(16'h0CF8, 2'd2, 1, 32'h8512_34A8, 0, 0, "R1 write fields", 1);
        access(16'h0CF8, 2'd2, 0, 0, 32'h8512_34A8, 1, "R1 readback low bits", 1);

        // R4 R5 R6 R8: window reads with responder dword 0xDEADBEEF
        resp_delay = 2;
        expect_req(0, 4'b1111, 0);
        access(16'h0CFC, 2'd2, 0, 0, 32'hDEAD_BEEF, 1, "R6 dword read", 0);
        resp_delay = 0;
        expect_req(0, 4'b0100, 0);
        access(16'h0CFE, 2'd0, 0, 0, 32'h0000_00AD, 1, "R6 byte read lane 2", 0);
        expect_req(0, 4'b1100, 0);
        access(16'h0CFF, 2'd1, 0, 0, 32'h0000_DEAD, 1, "R6 word read at offset 3 uses lane 2", 0);
        expect_req(0, 4'b1000, 0);
        access(16'h0CFF, 2'd0, 0, 0, 32'h0000_00DE, 1, "R6 byte read lane 3", 0);

        // R5: writes place data in lanes
        resp_delay = 1;
        expect_req(1, 4'b0010, 32'h0000_5A00);
        access(16'h0CFD, 2'd0, 1, 32'h5A, 0, 0, "R5 byte write", 0);
        expect_req(1, 4'b0011, 32'h0000_1234);
        access(16'h0CFC, 2'd1, 1, 32'h1234, 0, 0, "R5 word write low", 0);
        expect_req(1, 4'b1100, 32'h9876_0000);
        access(16'h0CFE, 2'd1, 1, 32'h9876, 0, 0, "R5 word write high", 0);

        // R2: partial index writes and reads
        access(16'h0CF9, 2'd0, 1, 32'h77, 0, 0, "R2 byte write", 1);
        access(16'h0CFA, 2'd1, 1, 32'hBEEF, 0, 0, "R2 word write", 1);
        access(16'h0CF8, 2'd2, 0, 0, 32'hBEEF_77A8, 1, "R2 partial merge", 1);
        access(16'h0CF9, 2'd0, 0, 0, 32'h0000_0077, 1, "R2 byte read", 1);
        access(16'h0CFA, 2'd1, 0, 0, 32'h0000_BEEF, 1, "R2 word read", 1);
        access(16'h0CF8, 2'd2, 1, 32'h8512_34A8, 0, 0, "R1 restore", 1);

        // R9: no responder
        no_resp = 1'b1;
        expect_req(0, 4'b1111, 0);
        access(16'h0CFC, 2'd2, 0, 0, 32'hFFFF_FFFF, 1, "R9 timeout read ones", 0);
        @(negedge clk);
        check("R9 request length", last_req_len, TIMEOUT);
        no_resp = 1'b0;

        // R7: enable bit clear
        access(16'h0CF8, 2'd2, 1, 32'h0512_34A8, 0, 0, "R7 clear enable", 1);
        r0 = req_rises;
        access(16'h0CFC, 2'd2, 1, 32'h1111_1111, 0, 0, "R7 disabled write", 1);
        access(16'h0CFD, 2'd0, 0, 0, 32'hFFFF_FFFF, 1, "R7 disabled read ones", 1);
        check("R7 no request when disabled", req_rises - r0, 32'd0);

        // R3: deselect with enable set
        access(16'h0CF8, 2'd2, 1, 32'h8512_34A8, 0, 0, "R3 enable", 1);
        access(16'h0CFB, 2'd0, 1, 32'h00, 0, 0, "R3 deselect", 1);
        r0 = req_rises;
        access(16'h0CFC, 2'd2, 0, 0, 32'hFFFF_FFFF, 1, "R3 deselected window ones", 1);
        check("R3 no request after deselect", req_rises - r0, 32'd0);
        access(16'h0CF8, 2'd2, 0, 0, 32'h8512_34A8, 1, "R3 index kept after deselect", 1);

        // R10: ports outside the range
        stray(16'h0CF4);
        stray(16'h0D00);
        stray(16'h1CF8);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule